// File: doc/BRIEF.md
# Immediate Add/Subtract Execute Unit

This block executes one 32-bit instruction word of the immediate arithmetic class per valid cycle. It splits the word into its fields and reads one source operand, either a general register or the stack pointer. It adds or subtracts a 12-bit unsigned constant, which may first be moved up by 12 bit positions. The result goes back to a register and, on request, to the four condition flags. The unit holds its own state: thirty-one 64-bit general registers, a 64-bit stack pointer and a 4-bit flag register. Debug outputs show that state.

Each word carries an operand-size bit. With it set, the whole 64 bits take part. With it clear, only the low 32 bits do, and any value written back has zero upper bits. Register number 31 names the stack pointer as a source. As a destination it names the stack pointer only when flags are not requested. When flags are requested it is a discard target.

Top module: `imm_arith_unit`

## Requirements
- R1: Instruction word fields are: bit 31 size (1 = 64-bit), bit 30 operation (1 = subtract), bit 29 flag-set, bits 28:23 the class pattern 100010, bit 22 shift, bits 21:10 the 12-bit constant, bits 9:5 source index, bits 4:0 destination index. A legal 64-bit add writes source + constant to the destination register.
- R2: With the shift bit set, the constant is the 12-bit field moved left by 12 bits. With it clear, the constant is the field zero-extended.
- R3: A subtract writes source − constant modulo 2^size. It is computed as source + inverted constant + 1.
- R4: In 32-bit mode only the low 32 bits of the source are used, and a result written to a general register has bits 63:32 equal to 0.
- R5: Source index 31 reads the stack pointer, cut to the operand size. Indices 0..30 read the general registers.
- R6: Destination index 31 with flag-set 0 writes the stack pointer with the result zero-extended to 64 bits.
- R7: Destination index 31 with flag-set 1 discards the result: no register and no stack pointer change. The flags are still written.
- R8: Flags change only when flag-set is 1. Flag output bit 3 = N (result sign), bit 2 = Z (result zero), bit 1 = C (carry out; for subtract 1 means no borrow), bit 0 = V (signed overflow). All are taken at the operand size.
- R9: A valid word whose bits 28:23 differ from 100010 raises `illegal` in the same cycle and changes no state.
- R10: An active-low synchronous reset clears all general registers, the stack pointer and the flags.
- R11: State changes at the clock edge that samples `in_valid` high, a fixed one-cycle latency whatever the data or flag values. With `in_valid` low, no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word |
| illegal | output | 1 | Valid word with wrong class pattern (combinational) |
| dbg_idx | input | 5 | General register selected for the debug port |
| dbg_gpr | output | 64 | Content of the selected register; 0 for index 31 |
| dbg_sp | output | 64 | Stack pointer |
| dbg_nzcv | output | 4 | Flags {N,Z,C,V} |

## Verification
The assertions assume that `in_valid` and `in_word` are settled before each rising edge. They also assume that `in_word` is don't-care while `in_valid` is low, so state is checked as stable only in cycles where no legal word is sampled. The stimulus drives inputs on the falling edge and holds them for a full cycle. It mixes directed words, a long run of 32-bit subtractions that reaches signed overflow, and random words, some with a broken class pattern. A behavioural model compares every register the unit could touch.

// File: rtl/imm_arith_pkg.sv
// Shared constants and the decoded-instruction record for the immediate
// add/subtract execute unit. Assumes a 64-bit register width.
package imm_arith_pkg;
    localparam int XLEN      = 64;
    localparam int HALF      = XLEN / 2;
    localparam int IDXW      = 5;
    localparam int NREG      = (1 << IDXW) - 1;
    localparam int IMMW      = 12;
    localparam int IMM_SHIFT = 12;
    localparam int CLSW      = 6;
    localparam logic [CLSW-1:0] CLASS_PAT = 6'b100010;
    localparam logic [IDXW-1:0] SP_IDX    = IDXW'(NREG);

    typedef struct packed {
        logic            legal;
        logic            is64;
        logic            sub;
        logic            setf;
        logic [XLEN-1:0] imm;
        logic [IDXW-1:0] rn;
        logic [IDXW-1:0] rd;
    } dec_t;
endpackage

// File: rtl/imm_decode.sv
// Field decoder: splits the instruction word and builds the 64-bit
// constant. Purely combinational; assumes the package field layout.
module imm_decode
    import imm_arith_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    logic [IMMW-1:0] imm_field;

    // Extract fields and form the optionally shifted, zero-extended constant.
    always_comb begin
        imm_field = word[21:10];
        dec.legal = (word[28:23] == CLASS_PAT);
        dec.is64  = word[31];
        dec.sub   = word[30];
        dec.setf  = word[29];
        dec.rn    = word[9:5];
        dec.rd    = word[4:0];
        if (word[22])
            dec.imm = XLEN'(imm_field) << IMM_SHIFT;
        else
            dec.imm = XLEN'(imm_field);
    end
endmodule

// File: rtl/imm_alu.sv
// Single adder with carry-in producing the result and {N,Z,C,V} at either
// operand size. Subtraction inverts the constant and injects a carry of 1.
// In 32-bit mode the result leaves with bits 63:32 cleared.
module imm_alu
    import imm_arith_pkg::*;
#(
    parameter int W = XLEN,
    parameter int H = HALF
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_imm,
    input  logic         sub,
    input  logic         is64,
    output logic [W-1:0] result,
    output logic [3:0]   nzcv
);
    logic [W-1:0] op_b;
    logic [W:0]   sum_w;
    logic [H:0]   sum_h;
    logic         sa, sb, c, n;

    // Add at both widths and pick size-dependent result and flag sources.
    always_comb begin
        op_b  = sub ? ~op_imm : op_imm;
        sum_w = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, sub};
        sum_h = {1'b0, op_a[H-1:0]} + {1'b0, op_b[H-1:0]} + {{H{1'b0}}, sub};
        if (is64) begin
            result = sum_w[W-1:0];
            c      = sum_w[W];
            sa     = op_a[W-1];
            sb     = op_b[W-1];
            n      = sum_w[W-1];
        end else begin
            result = {{(W-H){1'b0}}, sum_h[H-1:0]};
            c      = sum_h[H];
            sa     = op_a[H-1];
            sb     = op_b[H-1];
            n      = sum_h[H-1];
        end
        nzcv = {n, (result == '0), c, (sa == sb) && (n != sa)};
    end

    // R3: subtracting zero leaves the operand and reports no borrow.
    always_comb begin
        if (is64 && sub && op_imm == '0)
            p_sub_zero_r3: assert (result == op_a && nzcv[1]);
    end
endmodule

// File: rtl/arith_regfile.sv
// General registers, stack pointer and flag register with one operand read
// port (index 31 = stack pointer) and debug read-out. Assumes at most one of
// gpr_we / sp_we per cycle and write data already zero-extended.
module arith_regfile
    import imm_arith_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IDXW,
    parameter int NR = NREG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          gpr_we,
    input  logic          sp_we,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          wr_is64,
    input  logic          flag_we,
    input  logic [3:0]    flags_in,
    input  logic [IW-1:0] dbg_idx,
    output logic [W-1:0]  dbg_gpr,
    output logic [W-1:0]  sp_out,
    output logic [3:0]    nzcv_out
);
    logic [W-1:0] gpr_q [NR];
    logic [W-1:0] sp_q;
    logic [3:0]   nzcv_q;

    // Register array update and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) gpr_q[i] <= '0;
        end else if (gpr_we) begin
            gpr_q[wr_idx] <= wr_data;
        end
    end

    // Stack pointer and flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            nzcv_q <= '0;
        end else begin
            if (sp_we)   sp_q   <= wr_data;
            if (flag_we) nzcv_q <= flags_in;
        end
    end

    // Operand and debug read muxes; index NR maps to stack pointer / zero.
    always_comb begin
        rd_data  = (rd_idx  < IW'(NR)) ? gpr_q[rd_idx]  : sp_q;
        dbg_gpr  = (dbg_idx < IW'(NR)) ? gpr_q[dbg_idx] : '0;
        sp_out   = sp_q;
        nzcv_out = nzcv_q;
    end

    // R6: never two write targets in one cycle.
    always_comb begin
        p_one_target_r6: assert (!(gpr_we && sp_we));
    end

    // R6: a 32-bit stack pointer write leaves the upper half zero.
    p_sp_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we && !wr_is64 |=> sp_q[W-1:W/2] == '0);

    // R8: flags hold unless a flag write was requested.
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(nzcv_q));

    // R10: reset leaves stack pointer and flags cleared.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> sp_q == '0 && nzcv_q == '0);
endmodule

// File: rtl/imm_arith_unit.sv
// Top of the immediate add/subtract execute unit: decode, operand read,
// add/subtract and write-back in one cycle. Assumes in_word is settled
// whenever in_valid is high at a rising edge.
module imm_arith_unit
    import imm_arith_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_word,
    output logic            illegal,
    input  logic [IDXW-1:0] dbg_idx,
    output logic [XLEN-1:0] dbg_gpr,
    output logic [XLEN-1:0] dbg_sp,
    output logic [3:0]      dbg_nzcv
);
    dec_t            dec;
    logic [XLEN-1:0] src, res;
    logic [3:0]      flags;
    logic            go, gpr_we, sp_we, flag_we;

    imm_decode u_dec (.word(in_word), .dec(dec));

    imm_alu #(.W(XLEN), .H(HALF)) u_alu (
        .op_a(src), .op_imm(dec.imm), .sub(dec.sub), .is64(dec.is64),
        .result(res), .nzcv(flags)
    );

    // Write-enable steering: index 31 selects stack pointer or discard.
    always_comb begin
        go      = in_valid && dec.legal;
        illegal = in_valid && !dec.legal;
        gpr_we  = go && (dec.rd != SP_IDX);
        sp_we   = go && (dec.rd == SP_IDX) && !dec.setf;
        flag_we = go && dec.setf;
    end

    arith_regfile #(.W(XLEN), .IW(IDXW), .NR(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(dec.rn), .rd_data(src),
        .gpr_we(gpr_we), .sp_we(sp_we), .wr_idx(dec.rd), .wr_data(res),
        .wr_is64(dec.is64), .flag_we(flag_we), .flags_in(flags),
        .dbg_idx(dbg_idx), .dbg_gpr(dbg_gpr), .sp_out(dbg_sp), .nzcv_out(dbg_nzcv)
    );

    // R9: an illegal word changes neither stack pointer nor flags.
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(dbg_sp) && $stable(dbg_nzcv));

    // R11: no valid word, no state change.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dbg_sp) && $stable(dbg_nzcv));

    // R7: discard destination with flag-set keeps the stack pointer.
    p_discard_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !illegal && in_word[29] && in_word[4:0] == SP_IDX
        |=> $stable(dbg_sp));
endmodule

// File: tb/tb_imm_arith_unit.sv
module tb_imm_arith_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        illegal;
    logic [4:0]  dbg_idx = '0;
    logic [63:0] dbg_gpr, dbg_sp;
    logic [3:0]  dbg_nzcv;

    int nchk = 0;
    int nerr = 0;
    logic [63:0] m_gpr [31];
    logic [63:0] m_sp;
    logic [3:0]  m_nzcv;

    always #5 clk = ~clk;

    imm_arith_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .illegal(illegal), .dbg_idx(dbg_idx), .dbg_gpr(dbg_gpr),
        .dbg_sp(dbg_sp), .dbg_nzcv(dbg_nzcv)
    );

    function automatic logic [31:0] mk(input logic sf, op, s, sh,
                                       input logic [11:0] imm,
                                       input logic [4:0] rn, rd);
        return {sf, op, s, 6'b100010, sh, imm, rn, rd};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: apply one legal word to the model state.
    task automatic model_exec(input logic [31:0] w);
        logic [63:0] a, imm, r;
        logic c, v;
        int m;
        m   = w[31] ? 63 : 31;
        a   = (w[9:5] == 5'd31) ? m_sp : m_gpr[w[9:5]];
        if (!w[31]) a = {32'b0, a[31:0]};
        imm = w[22] ? {40'b0, w[21:10], 12'b0} : {52'b0, w[21:10]};
        if (w[30]) begin
            r = a - imm;
            c = (a >= imm);
            v = (a[m] != imm[m]) && (r[m] != a[m]);
        end else begin
            r = a + imm;
            c = w[31] ? (r < a) : r[32];
            v = (a[m] == imm[m]) && (r[m] != a[m]);
        end
        if (!w[31]) r = {32'b0, r[31:0]};
        if (w[29]) m_nzcv = {r[m], (r == 64'd0), c, v};
        if (w[4:0] == 5'd31) begin
            if (!w[29]) m_sp = r;
        end else begin
            m_gpr[w[4:0]] = r;
        end
    endtask

    // Drive one word for a cycle and compare all state it could touch.
    task automatic run(input logic [31:0] w, input string tag);
        logic bad;
        bad = (w[28:23] != 6'b100010);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        chk({tag, " R9 illegal flag"}, 64'(illegal), 64'(bad));
        if (!bad) model_exec(w);
        @(negedge clk);
        in_valid = 1'b0;
        dbg_idx  = w[4:0];
        #1;
        chk({tag, " R11 dest"}, dbg_gpr, (w[4:0] == 5'd31) ? 64'd0 : m_gpr[w[4:0]]);
        chk({tag, " R11 sp"}, dbg_sp, m_sp);
        chk({tag, " R8 nzcv"}, 64'(dbg_nzcv), 64'(m_nzcv));
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++) begin
            dbg_idx = 5'(i);
            #1;
            chk(tag, dbg_gpr, (i == 31) ? 64'd0 : m_gpr[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 31; i++) m_gpr[i] = '0;
        m_sp = '0;
        m_nzcv = '0;
        in_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 reset sp", dbg_sp, 64'd0);
        chk("R10 reset nzcv", 64'(dbg_nzcv), 64'd0);
        sweep("R10 reset regs");

        run(mk(1,0,0,0,12'd5,5'd2,5'd1), "R1 add");
        chk("R1 value", m_gpr[1], 64'd5);
        run(mk(1,0,0,1,12'd1,5'd1,5'd2), "R2 shifted add");
        chk("R2 value", m_gpr[2], 64'h1005);
        run(mk(1,1,0,0,12'd7,5'd1,5'd3), "R3 sub wrap");
        chk("R3 value", m_gpr[3], 64'hFFFF_FFFF_FFFF_FFFE);
        run(mk(1,1,1,0,12'd5,5'd1,5'd4), "R8 subs zero");
        chk("R8 flags", 64'(m_nzcv), 64'h6);
        run(mk(0,1,0,0,12'd0,5'd3,5'd5), "R4 w sub");
        chk("R4 value", m_gpr[5], 64'h0000_0000_FFFF_FFFE);
        run(mk(0,0,1,0,12'd2,5'd5,5'd6), "R4 adds carry");
        run(mk(1,0,0,0,12'h10,5'd2,5'd31), "R6 sp write");
        chk("R6 value", m_sp, 64'h1015);
        run(mk(1,0,0,0,12'd1,5'd31,5'd7), "R5 sp read");
        run(mk(0,1,0,0,12'd0,5'd3,5'd31), "R6 wsp zext");
        run(mk(1,0,0,0,12'd0,5'd3,5'd31), "R6 sp full");
        run(mk(0,0,0,0,12'd3,5'd31,5'd8), "R5 wsp trunc");
        chk("R5 value", m_gpr[8], 64'h1);
        run(mk(1,1,1,0,12'd6,5'd1,5'd31), "R7 discard");
        chk("R7 flags", 64'(m_nzcv), 64'h8);

        // 32-bit signed overflow: walk down to 0x80000000, then subtract 1.
        run(mk(1,1,0,1,12'h800,5'd20,5'd20), "R3 seed");
        for (int k = 0; k < 255; k++)
            run(mk(0,1,0,1,12'h800,5'd20,5'd20), "R4 walk");
        run(mk(0,1,1,0,12'd1,5'd20,5'd21), "R8 overflow");
        chk("R8 overflow value", m_gpr[21], 64'h7FFF_FFFF);
        chk("R8 overflow flags", 64'(m_nzcv), 64'h3);

        run({1'b1, 2'b00, 6'b100011, 1'b0, 12'd9, 5'd1, 5'd1}, "R9 bad class");
        @(negedge clk);
        in_word = mk(1,0,1,0,12'd1,5'd1,5'd1);
        @(negedge clk);
        dbg_idx = 5'd1;
        #1;
        chk("R11 idle reg", dbg_gpr, m_gpr[1]);
        chk("R11 idle sp", dbg_sp, m_sp);

        for (int k = 0; k < 600; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 5 != 0) w[28:23] = 6'b100010;
            run(w, "R1 random");
        end
        sweep("R1 final regs");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule